// File: doc/BRIEF.md
# DMA Write-Side Interrupt Status Register

This block collects single-cycle event pulses from the write (destination) side of a DMA engine into a 32-bit status word. The events are FIFO overflow, register access to an empty address, FIFO watermark reached, memory-side timeout, stream-side timeout and write-response error. Each event sets its own sticky bit. The bit stays set until software writes a 1 to it. The status is kept before masking, so software can see an event whose interrupt is masked. A separate mask input selects which bits drive the single interrupt output.

The block also decides when a command is complete. A pulse on `cmd_start` arms the tracker. The completion bit is then set once, and only once all four of these hold:

- the remaining byte count is zero;
- the final memory write has been issued;
- the destination FIFO is empty;
- the internal count of outstanding write responses has returned to zero.

The count goes up on each accepted write address and down on each accepted write response.

The register bus is a plain select/write/word-address port with combinational read data. The status word lives at word address `STS_ADDR`. Other word addresses flagged in `IMPL_MASK` belong to neighbouring registers. Any other address is treated as unimplemented.

Top module: `dma_wr_irq_status`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it rises, `raw_status`, `irq` and `bus_rdata` are all zero.
- R2: A pulse on an event input in cycle t makes the matching status bit read 1 from cycle t+1 onward, until it is cleared. The bit positions are: 7 FIFO overflow, 6 unimplemented access, 5 watermark, 4 memory timeout, 3 stream timeout, 2 write-response error, 1 done.
- R3: A bus write (`bus_sel`=1, `bus_wr`=1) to `STS_ADDR` clears each status bit whose `bus_wdata` bit is 1. Bits written with 0 keep their value.
- R4: If a set event and a write-1 clear reach the same bit in the same cycle, the bit ends up set.
- R5: Bits 31:8 and bit 0 of `bus_rdata` always read 0, and writing 1 to them has no effect.
- R6: An accepted write response (`b_valid` and `b_ready`) sets bit 2 when `b_resp` is 2 or 3, the two error codes. Codes 0 and 1 leave bit 2 unchanged.
- R7: A bus access (read or write) sets bit 6 when `bus_addr` is neither `STS_ADDR` nor a word flagged in `IMPL_MASK`. By default, words 0 to 15 are flagged and `STS_ADDR` is 5.
- R8: Bit 1 is set exactly once per `cmd_start`. It is set in the cycle after the one in which the tracker is armed, `size_zero`, `last_issued` and `fifo_empty` are all 1, and the outstanding count is zero.
- R9: The outstanding count rises on each `aw_valid`&`aw_ready` cycle and falls on each `b_valid`&`b_ready` cycle; while it is non-zero bit 1 is not set.
- R10: `irq` is 1 exactly when some status bit is 1 and its `irq_mask` bit is 0. `raw_status` is not affected by the mask.
- R11: A bus read (`bus_sel`=1, `bus_wr`=0) at `STS_ADDR` returns the status in bits 7:1 in the same cycle. Any other access returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_fifo_ovf | input | 1 | FIFO overflow pulse |
| evt_thresh | input | 1 | FIFO watermark pulse |
| evt_tmo_mem | input | 1 | Memory-side timeout pulse |
| evt_tmo_strm | input | 1 | Stream-side timeout pulse |
| aw_valid | input | 1 | Write address valid |
| aw_ready | input | 1 | Write address ready |
| b_valid | input | 1 | Write response valid |
| b_ready | input | 1 | Write response ready |
| b_resp | input | 2 | Write response code |
| cmd_start | input | 1 | Arms completion tracking for a new command |
| size_zero | input | 1 | Remaining byte count is zero |
| last_issued | input | 1 | Final memory write has been issued |
| fifo_empty | input | 1 | Destination FIFO is empty |
| bus_sel | input | 1 | Register bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data |
| irq_mask | input | 7 | Mask for status bits 7:1; 1 masks |
| raw_status | output | 7 | Unmasked status bits 7:1 |
| irq | output | 1 | Masked interrupt |

## Verification
Some behaviours are checked by the assertions on every cycle:

- the reserved read bits stay zero;
- no set bit drops without a matching write-1;
- a set beats a clear in the same cycle;
- error responses set bit 2;
- completion rises only after its conditions held with no response pending;
- `irq` agrees with the masked status.

Other behaviours can only be shown by the bench scenarios: each event landing on its own bit position, write-0 leaving bits alone, the address classification of flagged versus unflagged words, and completion firing exactly once per armed command. The bench shows these by comparing its behavioural model against the outputs every cycle, under directed and random traffic.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;
   localparam int unsigned WORD_W   = 32;
   localparam int unsigned STS_LO   = 1;
   localparam int unsigned STS_HI   = 7;
   localparam int unsigned NUM_EVT  = STS_HI - STS_LO + 1;
   localparam int unsigned RSVD_W   = WORD_W - STS_HI - 1;

   // bit positions inside the status word
   localparam int unsigned B_OVF    = 7;
   localparam int unsigned B_BADADR = 6;
   localparam int unsigned B_THRESH = 5;
   localparam int unsigned B_TMOMEM = 4;
   localparam int unsigned B_TMOSTR = 3;
   localparam int unsigned B_BERR   = 2;
   localparam int unsigned B_DONE   = 1;

   // write response codes with bit 1 set are errors
   localparam int unsigned RESP_ERR_BIT = 1;

   typedef logic [STS_HI:STS_LO] sts_vec_t;
endpackage

// File: rtl/dma_regbus_decode.sv
module dma_regbus_decode #(
   parameter int unsigned ADDR_W    = 6,
   parameter int unsigned STS_ADDR  = 5,
   parameter logic [(2**ADDR_W)-1:0] IMPL_MASK = 'hFFFF
) (
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   output logic              sts_rd,
   output logic              sts_wr,
   output logic              bad_addr
);
   localparam logic [ADDR_W-1:0] STS_A = ADDR_W'(STS_ADDR);

   logic hit_sts;
   logic hit_other;

   assign hit_sts   = (bus_addr == STS_A);
   assign hit_other = IMPL_MASK[bus_addr];

   assign sts_rd   = bus_sel & ~bus_wr & hit_sts;
   assign sts_wr   = bus_sel &  bus_wr & hit_sts;
   assign bad_addr = bus_sel & ~hit_sts & ~hit_other;
endmodule

// File: rtl/dma_outst_tracker.sv
module dma_outst_tracker #(
   parameter int unsigned CNT_W = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic aw_hs,
   input  logic b_hs,
   input  logic cmd_start,
   input  logic size_zero,
   input  logic last_issued,
   input  logic fifo_empty,
   output logic done_evt
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic [CNT_W-1:0] pend_q;
   logic             armed_q;
   logic             none_pending;

   assign none_pending = (pend_q == '0);
   assign done_evt = armed_q & size_zero & last_issued & fifo_empty & none_pending;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q <= '0;
      end else begin
         case ({aw_hs, b_hs})
            2'b10:   pend_q <= pend_q + ONE;
            2'b01:   pend_q <= pend_q - ONE;
            default: pend_q <= pend_q;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)         armed_q <= 1'b0;
      else if (cmd_start) armed_q <= 1'b1;
      else if (done_evt)  armed_q <= 1'b0;
   end
endmodule

// File: rtl/dma_sticky_bank.sv
module dma_sticky_bank #(
   parameter int unsigned W = 7
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] set_v,
   input  logic [W-1:0] clr_v,
   output logic [W-1:0] q
);
   for (genvar i = 0; i < W; i++) begin : g_bit
      logic bit_q;
      always_ff @(posedge clk) begin
         if (!rst_n)        bit_q <= 1'b0;
         else if (set_v[i]) bit_q <= 1'b1;
         else if (clr_v[i]) bit_q <= 1'b0;
      end
      assign q[i] = bit_q;
   end
endmodule

// File: rtl/dma_wr_irq_status.sv
module dma_wr_irq_status
   import dma_irq_pkg::*;
#(
   parameter int unsigned ADDR_W   = 6,
   parameter int unsigned STS_ADDR = 5,
   parameter logic [(2**ADDR_W)-1:0] IMPL_MASK = 'hFFFF,
   parameter int unsigned CNT_W    = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              evt_fifo_ovf,
   input  logic              evt_thresh,
   input  logic              evt_tmo_mem,
   input  logic              evt_tmo_strm,
   input  logic              aw_valid,
   input  logic              aw_ready,
   input  logic              b_valid,
   input  logic              b_ready,
   input  logic [1:0]        b_resp,
   input  logic              cmd_start,
   input  logic              size_zero,
   input  logic              last_issued,
   input  logic              fifo_empty,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   input  logic [7:1]        irq_mask,
   output logic [7:1]        raw_status,
   output logic              irq
);
   if (ADDR_W < 1 || ADDR_W > 12) begin : g_bad_addr_w
      $error("ADDR_W out of range");
   end
   if (STS_ADDR >= 2**ADDR_W) begin : g_bad_sts_addr
      $error("STS_ADDR beyond address space");
   end
   if (CNT_W < 2) begin : g_bad_cnt_w
      $error("CNT_W too small");
   end

   logic sts_rd, sts_wr, bad_addr;
   logic aw_hs, b_hs, berr, done_evt;
   sts_vec_t set_v, clr_v, sts_q;
   logic unused_wdata;

   assign aw_hs = aw_valid & aw_ready;
   assign b_hs  = b_valid & b_ready;
   assign berr  = b_hs & b_resp[RESP_ERR_BIT];

   dma_regbus_decode #(
      .ADDR_W(ADDR_W), .STS_ADDR(STS_ADDR), .IMPL_MASK(IMPL_MASK)
   ) u_dec (
      .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .sts_rd(sts_rd), .sts_wr(sts_wr), .bad_addr(bad_addr)
   );

   dma_outst_tracker #(.CNT_W(CNT_W)) u_trk (
      .clk(clk), .rst_n(rst_n), .aw_hs(aw_hs), .b_hs(b_hs),
      .cmd_start(cmd_start), .size_zero(size_zero),
      .last_issued(last_issued), .fifo_empty(fifo_empty),
      .done_evt(done_evt)
   );

   always_comb begin
      set_v           = '0;
      set_v[B_OVF]    = evt_fifo_ovf;
      set_v[B_BADADR] = bad_addr;
      set_v[B_THRESH] = evt_thresh;
      set_v[B_TMOMEM] = evt_tmo_mem;
      set_v[B_TMOSTR] = evt_tmo_strm;
      set_v[B_BERR]   = berr;
      set_v[B_DONE]   = done_evt;
   end

   assign clr_v = sts_wr ? bus_wdata[STS_HI:STS_LO] : '0;
   assign unused_wdata = ^{bus_wdata[WORD_W-1:STS_HI+1], bus_wdata[0]};

   dma_sticky_bank #(.W(NUM_EVT)) u_bank (
      .clk(clk), .rst_n(rst_n), .set_v(set_v), .clr_v(clr_v), .q(sts_q)
   );

   assign raw_status = sts_q;
   assign irq        = |(sts_q & ~irq_mask);
   assign bus_rdata  = sts_rd ? {{RSVD_W{1'b0}}, sts_q, 1'b0} : '0;
endmodule

// File: rtl/dma_wr_irq_status_chk.sv
module dma_wr_irq_status_chk #(
   parameter int unsigned ADDR_W   = 6,
   parameter int unsigned STS_ADDR = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              evt_fifo_ovf,
   input logic              aw_hs,
   input logic              b_hs,
   input logic [1:0]        b_resp,
   input logic              size_zero,
   input logic              last_issued,
   input logic              fifo_empty,
   input logic              bus_sel,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [7:1]        clr_bits,
   input logic [31:0]       bus_rdata,
   input logic [7:1]        irq_mask,
   input logic [7:1]        raw_status,
   input logic              irq
);
   logic       clr_hit, rd_hit;
   logic [7:1] keep_q;
   logic [15:0] pend_q;

   assign clr_hit = bus_sel && bus_wr && (bus_addr == ADDR_W'(STS_ADDR));
   assign rd_hit  = bus_sel && !bus_wr && (bus_addr == ADDR_W'(STS_ADDR));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         keep_q <= '0;
         pend_q <= '0;
      end else begin
         keep_q <= raw_status & ~(clr_hit ? clr_bits : 7'd0);
         pend_q <= pend_q + {15'd0, aw_hs} - {15'd0, b_hs};
      end
   end

   AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rdata[31:8] == 24'd0) && !bus_rdata[0]);                          // R5
   AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (raw_status & keep_q) == keep_q);                                     // R3
   AST_OVF_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      evt_fifo_ovf |=> raw_status[7]);                                      // R2
   AST_SET_OVER_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_fifo_ovf && clr_hit && clr_bits[7]) |=> raw_status[7]);          // R4
   AST_BERR_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      (b_hs && b_resp[1]) |=> raw_status[2]);                               // R6
   AST_DONE_COND: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(raw_status[1]) |-> $past(size_zero && last_issued && fifo_empty)); // R8
   AST_DONE_NO_PEND: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(raw_status[1]) |-> ($past(pend_q) == 16'd0));                   // R9
   AST_IRQ_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      !irq |-> ((raw_status & ~irq_mask) == 7'd0));                         // R10
   AST_IRQ_ON: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> ((raw_status & ~irq_mask) != 7'd0));                          // R10
   AST_READ_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      rd_hit |-> (bus_rdata[7:1] == raw_status));                           // R11
endmodule

bind dma_wr_irq_status dma_wr_irq_status_chk #(
   .ADDR_W(ADDR_W), .STS_ADDR(STS_ADDR)
) u_chk (
   .clk(clk), .rst_n(rst_n), .evt_fifo_ovf(evt_fifo_ovf),
   .aw_hs(aw_valid && aw_ready), .b_hs(b_valid && b_ready), .b_resp(b_resp),
   .size_zero(size_zero), .last_issued(last_issued), .fifo_empty(fifo_empty),
   .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
   .clr_bits(bus_wdata[7:1]), .bus_rdata(bus_rdata), .irq_mask(irq_mask),
   .raw_status(raw_status), .irq(irq)
);

// File: tb/dma_wr_irq_status_test.sv
`timescale 1ns/1ps
module dma_wr_irq_status_test;
   localparam int ADDR_W = 6;
   localparam int STS    = 5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic evt_fifo_ovf = 0, evt_thresh = 0, evt_tmo_mem = 0, evt_tmo_strm = 0;
   logic aw_valid = 0, aw_ready = 0, b_valid = 0, b_ready = 0;
   logic [1:0] b_resp = 0;
   logic cmd_start = 0, size_zero = 0, last_issued = 0, fifo_empty = 0;
   logic bus_sel = 0, bus_wr = 0;
   logic [ADDR_W-1:0] bus_addr = 0;
   logic [31:0] bus_wdata = 0, bus_rdata;
   logic [7:1] irq_mask = 0, raw_status;
   logic irq;

   int vectors = 0, errors = 0;
   string phase = "R1";
   bit finished = 0;

   logic [7:1] m_sts;
   bit m_armed;
   int m_outst;

   always #4 clk = ~clk;

   dma_wr_irq_status uut (.*);

   // behavioural reference, updated on each rising edge
   always @(posedge clk) begin
      logic [7:1] s, c;
      bit de, bad;
      if (!rst_n) begin
         m_sts = 0; m_armed = 0; m_outst = 0;
      end else begin
         de  = m_armed && size_zero && last_issued && fifo_empty && (m_outst == 0);
         bad = bus_sel && (bus_addr != STS) && !(bus_addr < 16);
         s = {evt_fifo_ovf, bad, evt_thresh, evt_tmo_mem, evt_tmo_strm,
              (b_valid && b_ready && b_resp >= 2), de};
         c = (bus_sel && bus_wr && bus_addr == STS) ? bus_wdata[7:1] : 7'd0;
         m_sts   = (m_sts & ~c) | s;
         m_armed = cmd_start || (m_armed && !de);
         m_outst = m_outst + int'(aw_valid && aw_ready) - int'(b_valid && b_ready);
      end
   end

   // compare on every falling edge
   always @(negedge clk) begin
      logic [31:0] exp_rd;
      bit exp_irq;
      if (!finished) begin
         exp_rd  = (bus_sel && !bus_wr && bus_addr == STS) ? {24'd0, m_sts, 1'b0} : 32'd0;
         exp_irq = |(m_sts & ~irq_mask);
         vectors++;
         if (raw_status !== m_sts) begin
            errors++;
            $display("FAIL %s raw_status got %h exp %h", phase, raw_status, m_sts);
         end
         if (irq !== exp_irq) begin
            errors++;
            $display("FAIL %s/R10 irq got %b exp %b", phase, irq, exp_irq);
         end
         if (bus_rdata !== exp_rd) begin
            errors++;
            $display("FAIL %s/R11 bus_rdata got %h exp %h", phase, bus_rdata, exp_rd);
         end
      end
   end

   task automatic cyc(int n = 1);
      repeat (n) begin @(negedge clk); #1; end
   endtask

   task automatic bus_op(bit wr, int a, logic [31:0] d);
      bus_sel = 1; bus_wr = wr; bus_addr = ADDR_W'(a); bus_wdata = d;
      cyc();
      bus_sel = 0; bus_wr = 0; bus_wdata = 0;
   endtask

   initial begin
      #(8 * 150000);
      errors++;
      $display("FAIL watchdog expired");
      finished = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end

   initial begin
      cyc(4);
      phase = "R1";
      rst_n = 1;
      cyc(2);
      // R2: each event alone, then read back
      phase = "R2";
      evt_fifo_ovf = 1; cyc(); evt_fifo_ovf = 0;
      evt_thresh = 1;   cyc(); evt_thresh = 0;
      evt_tmo_mem = 1;  cyc(); evt_tmo_mem = 0;
      evt_tmo_strm = 1; cyc(); evt_tmo_strm = 0;
      bus_op(0, STS, 0);
      // R3: write 0 keeps, write 1 clears selected bits
      phase = "R3";
      bus_op(1, STS, 32'h0);
      bus_op(1, STS, 32'h0000_00A0);
      bus_op(0, STS, 0);
      bus_op(1, STS, 32'h0000_00FE);
      // R4: set and clear together
      phase = "R4";
      evt_thresh = 1; bus_op(1, STS, 32'h0000_0020); evt_thresh = 0;
      bus_op(0, STS, 0);
      // R5: reserved bits
      phase = "R5";
      bus_op(1, STS, 32'hFFFF_FF01);
      bus_op(0, STS, 0);
      bus_op(1, STS, 32'hFFFF_FFFF);
      // R6: response codes 0..3
      phase = "R6";
      for (int k = 0; k < 4; k++) begin
         aw_valid = 1; aw_ready = 1; cyc(); aw_valid = 0; aw_ready = 0;
         b_valid = 1; b_ready = 1; b_resp = 2'(k); cyc();
         b_valid = 0; b_ready = 0; b_resp = 0;
         bus_op(0, STS, 0);
         bus_op(1, STS, 32'h4);
      end
      // R7: flagged and unflagged addresses
      phase = "R7";
      bus_op(0, 10, 0); bus_op(1, 15, 32'hFF);
      bus_op(0, 0, 0);
      bus_op(0, 40, 0); bus_op(0, STS, 0);
      bus_op(1, STS, 32'h40);
      bus_op(1, 63, 32'h40); bus_op(0, STS, 0);
      bus_op(1, STS, 32'hFE);
      // R8 / R9: completion gated by conditions and pending responses
      phase = "R8";
      cmd_start = 1; cyc(); cmd_start = 0;
      aw_valid = 1; aw_ready = 1; cyc(3); aw_valid = 0; aw_ready = 0;
      size_zero = 1; last_issued = 1; cyc(2);
      phase = "R9";
      fifo_empty = 1; cyc(2);
      b_valid = 1; b_ready = 1; cyc(2);
      b_valid = 0; cyc(2);
      b_valid = 1; cyc(); b_valid = 0; b_ready = 0;
      cyc(3);
      phase = "R8";
      bus_op(0, STS, 0);
      bus_op(1, STS, 32'h2); cyc(3);
      size_zero = 0; last_issued = 0; fifo_empty = 0;
      // R10: masking
      phase = "R10";
      evt_tmo_mem = 1; evt_fifo_ovf = 1; cyc(); evt_tmo_mem = 0; evt_fifo_ovf = 0;
      irq_mask = 7'h40; cyc(); irq_mask = 7'h48; cyc(); irq_mask = 7'h7F; cyc();
      irq_mask = 7'h00; cyc();
      // R11: reads elsewhere return zero
      phase = "R11";
      bus_op(0, 3, 0); bus_op(0, STS, 0); bus_op(0, 50, 0);
      bus_op(1, STS, 32'hFE);
      // random traffic
      phase = "R2-random";
      for (int i = 0; i < 3000; i++) begin
         evt_fifo_ovf = ($urandom % 16) == 0;
         evt_thresh   = ($urandom % 16) == 0;
         evt_tmo_mem  = ($urandom % 16) == 0;
         evt_tmo_strm = ($urandom % 16) == 0;
         aw_valid = ($urandom % 4) == 0; aw_ready = $urandom % 2;
         b_valid  = (m_outst > 1) && ($urandom % 3 == 0); b_ready = 1;
         b_resp   = 2'($urandom);
         cmd_start   = ($urandom % 40) == 0;
         size_zero   = $urandom % 2;
         last_issued = $urandom % 2;
         fifo_empty  = $urandom % 2;
         bus_sel  = ($urandom % 3) == 0;
         bus_wr   = $urandom % 2;
         bus_addr = ($urandom % 2) ? ADDR_W'(STS) : ADDR_W'($urandom);
         bus_wdata = $urandom;
         irq_mask  = 7'($urandom);
         cyc();
      end
      evt_fifo_ovf = 0; evt_thresh = 0; evt_tmo_mem = 0; evt_tmo_strm = 0;
      aw_valid = 0; b_valid = 0; cmd_start = 0; bus_sel = 0; bus_wr = 0;
      cyc(3);
      phase = "R1";
      rst_n = 0; cyc(2); rst_n = 1; cyc(2);
      finished = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end
endmodule